// File: doc/BRIEF.md
# Cycle Counter Unit with Register Port

This block is a cycle counter of the kind found in a performance monitor. It sits behind a small synchronous register port. Counting starts only when two enables are set. One is a global enable in a control word. The other is a per-counter enable, changed through separate set and clear registers: a 1 in the enable position sets or clears it, and a 0 leaves it alone. A one-shot bit in the control word zeroes the counter. Software may also write the counter directly.

Every access carries a privilege flag. An access-permission register, writable only by privileged software, decides whether unprivileged accesses may reach the other registers. A blocked write is dropped. A blocked read returns zero and raises an error flag alongside the read data.

Register map (word index on `bus_addr`):

| Index | Name | Contents |
|---|---|---|
| 0 | CTRL | bit 0 global enable, bit 2 counter reset (write 1) |
| 1 | CEN_SET | bit 31 counter enable |
| 2 | CEN_CLR | bit 31 counter enable |
| 3 | UACC | bit 0 unprivileged access allowed |
| 4 | COUNT | counter value |

Top module: `cyc_mon_unit`

## Requirements
- R1: After reset, every register reads 0, `bus_rdata` is 0 and `bus_err` is 0.
- R2: Bit 0 of CTRL (index 0) is the global enable. While it is 0 the counter never increments.
- R3: Writing 1 to bit 31 of CEN_SET (index 1) sets the counter enable, and a 0 in bit 31 leaves the enable unchanged. Reading CEN_SET or CEN_CLR returns the enable in bit 31 and 0 in every other bit.
- R4: Writing 1 to bit 31 of CEN_CLR (index 2) clears the counter enable, and a 0 in bit 31 leaves the enable unchanged.
- R5: The counter adds exactly one on each clock edge at which both enables are 1. On any other edge it holds its value, unless it is cleared or loaded.
- R6: Writing CTRL with bit 2 set zeroes the counter at that edge, and bit 2 always reads back 0. The reset takes priority over counting. If the same write sets bit 0, the first increment happens one edge later.
- R7: A read is registered. The clock edge that samples `bus_rd` puts the addressed register's value from just before that edge on `bus_rdata`. `bus_rdata` then holds until the next read, so COUNT can be read at any time.
- R8: A permitted write to COUNT (index 4) loads the written value at that edge.
- R9: The counter wraps from 0xFFFFFFFF to 0 and keeps counting.
- R10: Bit 0 of UACC (index 3), when 1, lets unprivileged accesses (`bus_priv`=0) reach CTRL, CEN_SET, CEN_CLR and COUNT. UACC can be written only by privileged accesses.
- R11: While UACC bit 0 is 0, an unprivileged write changes no register. An unprivileged read returns 0 with `bus_err`=1 for that read. `bus_err` is 0 for every permitted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | 1 for a privileged access |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_err | output | 1 | Access-denied flag for the current read response |

## Verification
The counter is exercised in four enable combinations: neither enable, only the global enable, only the per-counter enable, and both. Only the last combination may change the value between two reads. Two reads taken back to back, and two reads with a known idle gap between them, check the step of exactly one per edge. A reset written together with the global enable separates reset priority from counting. A load of all ones checks the wrap. Unprivileged accesses are tried with the permission bit both clear and set, so that dropped writes and error responses are separated from the normal path.

// File: rtl/cyc_mon_pkg.sv
package cyc_mon_pkg;

   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_CSET  = 3'd1,
      REG_CCLR  = 3'd2,
      REG_UACC  = 3'd3,
      REG_COUNT = 3'd4
   } reg_sel_e;

   localparam int unsigned CTRL_GEN_BIT = 0;
   localparam int unsigned CTRL_RST_BIT = 2;
   localparam int unsigned CEN_BIT      = 31;
   localparam int unsigned UACC_BIT     = 0;
   localparam int unsigned MIN_ADDR_W   = 3;
   localparam int unsigned MIN_DATA_W   = 32;

   typedef struct packed {
      logic ctrl;
      logic cset;
      logic cclr;
      logic uacc;
      logic count;
   } reg_hit_t;

endpackage

// File: rtl/cyc_mon_decode.sv
module cyc_mon_decode
   import cyc_mon_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_priv,
   input  logic              uacc_en,
   output reg_hit_t          wr_hit,
   output reg_hit_t          rd_hit,
   output logic              rd_denied
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(REG_CSET);
   localparam logic [ADDR_W-1:0] A_CCLR  = ADDR_W'(REG_CCLR);
   localparam logic [ADDR_W-1:0] A_UACC  = ADDR_W'(REG_UACC);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(REG_COUNT);

   logic     allowed;
   reg_hit_t sel;

   assign allowed = bus_priv | uacc_en;

   always_comb begin
      sel       = '0;
      sel.ctrl  = (bus_addr == A_CTRL);
      sel.cset  = (bus_addr == A_CSET);
      sel.cclr  = (bus_addr == A_CCLR);
      sel.uacc  = (bus_addr == A_UACC);
      sel.count = (bus_addr == A_COUNT);
   end

   always_comb begin
      wr_hit       = '0;
      wr_hit.ctrl  = bus_wr & allowed & sel.ctrl;
      wr_hit.cset  = bus_wr & allowed & sel.cset;
      wr_hit.cclr  = bus_wr & allowed & sel.cclr;
      wr_hit.uacc  = bus_wr & bus_priv & sel.uacc;
      wr_hit.count = bus_wr & allowed & sel.count;
   end

   always_comb begin
      rd_hit = '0;
      if (bus_rd && allowed) begin
         rd_hit = sel;
      end
   end

   assign rd_denied = bus_rd & ~allowed;

   // R10
   uacc_wr_priv_chk: assert property (@(posedge wr_hit.uacc) bus_priv)
      else $error("UACC written without privilege");

   // R11
   denied_wr_none_chk: assert final ((bus_priv || uacc_en) || (wr_hit == '0))
      else $error("denied write produced a strobe");

endmodule

// File: rtl/cyc_mon_enables.sv
module cyc_mon_enables
   import cyc_mon_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_hit_t          wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              gen_q,
   output logic              cen_q,
   output logic              uacc_q,
   output logic              cnt_clr
);

   logic gen_d, cen_d, uacc_d;

   always_comb begin
      gen_d  = gen_q;
      cen_d  = cen_q;
      uacc_d = uacc_q;
      if (wr_hit.ctrl) begin
         gen_d = wdata[CTRL_GEN_BIT];
      end
      if (wr_hit.cset && wdata[CEN_BIT]) begin
         cen_d = 1'b1;
      end
      if (wr_hit.cclr && wdata[CEN_BIT]) begin
         cen_d = 1'b0;
      end
      if (wr_hit.uacc) begin
         uacc_d = wdata[UACC_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q  <= 1'b0;
         cen_q  <= 1'b0;
         uacc_q <= 1'b0;
      end else begin
         gen_q  <= gen_d;
         cen_q  <= cen_d;
         uacc_q <= uacc_d;
      end
   end

   assign cnt_clr = wr_hit.ctrl & wdata[CTRL_RST_BIT];

   // R3
   cen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit.cset && wdata[CEN_BIT]) |=> cen_q)
      else $error("enable not set");

   // R4
   cen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit.cclr && wdata[CEN_BIT]) |=> !cen_q)
      else $error("enable not cleared");

   // R3
   cen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_hit.cset && wdata[CEN_BIT]) && !(wr_hit.cclr && wdata[CEN_BIT])) |=> $stable(cen_q))
      else $error("enable changed without a 1 in its bit");

endmodule

// File: rtl/cyc_mon_counter.sv
module cyc_mon_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr) begin
         cnt_d = '0;
      end else if (ld) begin
         cnt_d = ld_val;
      end else if (run) begin
         cnt_d = cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   // R5
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !ld) |=> (cnt_q == $past(cnt_q) + ONE))
      else $error("counter did not step by one");

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr && !ld) |=> $stable(cnt_q))
      else $error("counter moved while stopped");

   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0))
      else $error("counter not cleared");

   // R8
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr) |=> (cnt_q == $past(ld_val)))
      else $error("counter not loaded");

endmodule

// File: rtl/cyc_mon_unit.sv
module cyc_mon_unit
   import cyc_mon_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter bit          RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);

   localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << CEN_BIT;

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too small for the register map");
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      initial $fatal(1, "DATA_W must hold bit 31");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      initial $fatal(1, "CNT_W out of range");
   end

   reg_hit_t          wr_hit, rd_hit;
   logic              rd_denied;
   logic              gen_q, cen_q, uacc_q, cnt_clr;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] rd_mux;

   cyc_mon_decode #(.ADDR_W(ADDR_W)) u_decode (
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_priv (bus_priv),
      .uacc_en  (uacc_q),
      .wr_hit   (wr_hit),
      .rd_hit   (rd_hit),
      .rd_denied(rd_denied)
   );

   cyc_mon_enables #(.DATA_W(DATA_W)) u_enables (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (bus_wdata),
      .gen_q  (gen_q),
      .cen_q  (cen_q),
      .uacc_q (uacc_q),
      .cnt_clr(cnt_clr)
   );

   cyc_mon_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (gen_q & cen_q),
      .clr   (cnt_clr),
      .ld    (wr_hit.count),
      .ld_val(bus_wdata[CNT_W-1:0]),
      .cnt_q (cnt_q)
   );

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         rd_hit.ctrl:  rd_mux[CTRL_GEN_BIT] = gen_q;
         rd_hit.cset:  rd_mux = cen_q ? EN_MASK : '0;
         rd_hit.cclr:  rd_mux = cen_q ? EN_MASK : '0;
         rd_hit.uacc:  rd_mux[UACC_BIT] = uacc_q;
         rd_hit.count: rd_mux = DATA_W'(cnt_q);
         default:      rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      logic              err_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
         end else if (bus_rd) begin
            rdata_q <= rd_mux;
            err_q   <= rd_denied;
         end else begin
            err_q   <= 1'b0;
         end
      end

      assign bus_rdata = rdata_q;
      assign bus_err   = err_q;

      // R11
      deny_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && !bus_priv && !uacc_q) |=> (bus_err && bus_rdata == '0))
         else $error("denied read not flagged");

      // R11
      priv_rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_priv) |=> !bus_err)
         else $error("error on permitted read");

      // R6
      rst_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(REG_CTRL)) |=> !bus_rdata[CTRL_RST_BIT])
         else $error("reset bit read back as 1");
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
      assign bus_err   = rd_denied;
   end

   // R11
   deny_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_priv && !uacc_q) |=> ($stable(gen_q) && $stable(cen_q) && $stable(uacc_q)))
      else $error("denied write changed state");

   // R10
   uacc_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_priv) |=> $stable(uacc_q))
      else $error("unprivileged write changed UACC");

   // R2
   gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !wr_hit.count && !cnt_clr) |=> $stable(cnt_q))
      else $error("counter moved with global enable off");

endmodule

// File: tb/cyc_mon_unit_tb.sv
module cyc_mon_unit_tb;

   localparam int unsigned AW = 3;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_priv = 1'b1;
   logic [DW-1:0] bus_rdata;
   logic          bus_err;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cyc_mon_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_priv (bus_priv),
      .bus_rdata(bus_rdata),
      .bus_err  (bus_err)
   );

   localparam logic [AW-1:0] CTRL = 3'd0, CSET = 3'd1, CCLR = 3'd2, UACC = 3'd3, COUNT = 3'd4;
   localparam logic [31:0]   B31 = 32'h8000_0000;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic p = 1'b1);
      bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_priv = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic e,
                     input logic p = 1'b1);
      bus_addr = a; bus_priv = p; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_priv = 1'b1;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic t_reset();
      logic [31:0] d; logic e;
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R1 err", {31'h0, bus_err}, 32'h0);
      rd(CTRL, d, e);  chk("R1 CTRL", d, 32'h0);
      rd(CSET, d, e);  chk("R1 CEN_SET", d, 32'h0);
      rd(UACC, d, e);  chk("R1 UACC", d, 32'h0);
      rd(COUNT, d, e); chk("R1 COUNT", d, 32'h0);
   endtask

   task automatic t_single_enable();
      logic [31:0] a, b; logic e;
      wr(CTRL, 32'h1);
      rd(COUNT, a, e); repeat (4) @(negedge clk); rd(COUNT, b, e);
      chk("R5 hold with only global enable", b, a);
      wr(CTRL, 32'h0);
      wr(CSET, B31);
      rd(COUNT, a, e); repeat (4) @(negedge clk); rd(COUNT, b, e);
      chk("R2 hold with global enable off", b, a);
      rd(CSET, a, e); chk("R3 CEN_SET readback", a, B31);
      rd(CCLR, a, e); chk("R3 CEN_CLR readback", a, B31);
   endtask

   task automatic t_set_clear();
      logic [31:0] d; logic e;
      wr(CCLR, B31);
      rd(CSET, d, e); chk("R4 clear enable", d, 32'h0);
      wr(CSET, 32'h7FFF_FFFF);
      rd(CSET, d, e); chk("R3 zero in bit31 ignored", d, 32'h0);
      wr(CSET, B31);
      wr(CCLR, 32'h7FFF_FFFF);
      rd(CCLR, d, e); chk("R4 zero in bit31 ignored", d, B31);
   endtask

   task automatic t_count();
      logic [31:0] a, b; logic e;
      wr(CSET, B31);
      wr(CTRL, 32'h1);
      rd(COUNT, a, e); rd(COUNT, b, e);
      chk("R5 back-to-back step", b - a, 32'd1);
      rd(COUNT, a, e); repeat (5) @(negedge clk); rd(COUNT, b, e);
      chk("R7 step over gap", b - a, 32'd6);
      wr(CCLR, B31);
      rd(COUNT, a, e); repeat (3) @(negedge clk); rd(COUNT, b, e);
      chk("R5 hold after enable cleared", b, a);
   endtask

   task automatic t_reset_prio();
      logic [31:0] d; logic e;
      wr(CTRL, 32'h0);
      wr(CSET, B31);
      wr(COUNT, 32'd100);
      rd(COUNT, d, e); chk("R8 load", d, 32'd100);
      wr(CTRL, 32'h5);
      rd(COUNT, d, e); chk("R6 reset wins over enable", d, 32'd0);
      rd(COUNT, d, e); chk("R6 count starts next edge", d, 32'd1);
      rd(CTRL, d, e);  chk("R6 reset bit reads 0", d, 32'h1);
   endtask

   task automatic t_wrap();
      logic [31:0] d; logic e;
      wr(CCLR, B31);
      wr(CTRL, 32'h1);
      wr(COUNT, 32'hFFFF_FFFF);
      wr(CSET, B31);
      rd(COUNT, d, e); chk("R9 top value", d, 32'hFFFF_FFFF);
      rd(COUNT, d, e); chk("R9 wrap to zero", d, 32'h0);
      rd(COUNT, d, e); chk("R9 keeps counting", d, 32'h1);
   endtask

   task automatic t_user();
      logic [31:0] d, keep; logic e;
      wr(CTRL, 32'h0);
      wr(CTRL, 32'h1, 1'b0);
      rd(CTRL, d, e); chk("R11 unpriv write dropped", d, 32'h0);
      rd(COUNT, keep, e);
      wr(COUNT, 32'd55, 1'b0);
      rd(COUNT, d, e, 1'b0);
      chk("R11 denied read data", d, 32'h0);
      chk("R11 denied read err", {31'h0, e}, 32'h1);
      rd(COUNT, d, e);
      chk("R11 count kept", d, keep);
      chk("R11 priv read err", {31'h0, e}, 32'h0);
      wr(UACC, 32'h1);
      wr(COUNT, 32'h1234, 1'b0);
      rd(COUNT, d, e, 1'b0);
      chk("R10 unpriv load", d, 32'h1234);
      chk("R10 unpriv err", {31'h0, e}, 32'h0);
      wr(UACC, 32'h0, 1'b0);
      rd(UACC, d, e); chk("R10 UACC priv only", d, 32'h1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_enable();
      t_set_clear();
      t_count();
      t_reset_prio();
      t_wrap();
      t_user();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule